// File: doc/BRIEF.md
# Prescaled 16-bit Timer with Free-Running and Clear-on-Match Modes

This block is a 16-bit up-counter fed by a clock divider. A three-bit select picks the division ratio or halts the count. A single mode bit chooses between two behaviours. In free-running mode the count wraps from all ones back to zero. In clear-on-match mode the count returns to zero after it reaches compare value A. Each compare value has its own match flag, and an overflow flag marks the wrap from all ones. Each flag drives an interrupt request when its enable input is high. A flag clears when its bit is written with 1 or when its acknowledge input is pulsed.

Software reaches the counter and both compare values over an 8-bit register bus. One staging byte is shared by all three 16-bit registers, so the two halves of a value always stay together. A high-byte write fills the staging byte. The low-byte write then loads all 16 bits in one cycle. A low-byte read copies the matching high byte into the staging byte, and the next high-byte read returns that copy.

The divider runs a small state machine with two states, RUN_STOPPED and RUN_ACTIVE. The transition start goes from RUN_STOPPED to RUN_ACTIVE when the select holds a valid divisor code. The transition halt goes from RUN_ACTIVE to RUN_STOPPED when the select holds a stop code. Both states hold on any other input. Divider ticks occur only in RUN_ACTIVE.

Top module: `prescaled_timer16`

## Requirements
- R1: After reset the counter, both compare values, the staging byte and all three flags are zero, and every interrupt request is low.
- R2: The select codes are 0 for stop, 1 for divide by 1, 2 for divide by 8, 3 for divide by 64, 4 for divide by 256 and 5 for divide by 1024. Codes 6 and 7 also stop. The select may leave a stop code at a falling edge; counting the rising edges from there, the first tick comes on edge 1+div and later ticks come every div edges. Two ticks in a row are possible only with divide by 1.
- R3: With the mode bit at 0 (free-running), each tick adds one to the count, and the count wraps from 0xFFFF to 0.
- R4: With the mode bit at 1 (clear-on-match), a tick that finds the count equal to compare A loads 0, and any other tick adds one.
- R5: A tick that finds the count equal to compare A sets flag bit 0. A tick that finds the count equal to compare B sets flag bit 1.
- R6: A tick that finds the count at 0xFFFF sets flag bit 2 (overflow).
- R7: Each interrupt request equals its flag ANDed with the matching bit of irq_en. Bit 0 is match A, bit 1 is match B and bit 2 is overflow.
- R8: Writing the flag register (address 6) clears each flag whose bit is written as 1. A bit written as 0 has no effect. A flag being set wins over a clear in the same cycle.
- R9: A one-cycle pulse on a bit of irq_ack clears the matching flag.
- R10: The byte addresses are: counter low 0, counter high 1, compare A low 2, compare A high 3, compare B low 4, compare B high 5. A high-byte write changes only the staging byte. A low-byte write loads {staging, data} into the register, and this load takes priority over a tick in that cycle.
- R11: A low-byte read returns the low byte and copies the high byte of the same register into the staging byte. A high-byte read returns the staging byte and leaves it unchanged.
- R12: While stopped, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_sel | input | 3 | Divider select / stop |
| ctc_mode | input | 1 | 0 free-running, 1 clear-on-match A |
| irq_en | input | 3 | Interrupt enables {ovf, B, A} |
| irq_ack | input | 3 | Flag clear pulses {ovf, B, A} |
| bus_addr | input | 3 | Register byte address |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| flag_cmp_a | output | 1 | Match A flag |
| flag_cmp_b | output | 1 | Match B flag |
| flag_ovf | output | 1 | Overflow flag |
| irq_cmp_a | output | 1 | Match A interrupt request |
| irq_cmp_b | output | 1 | Match B interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |

## Verification
A divider phase that is off by one edge changes the tick count over a long run, so the counter read back after a fixed number of edges differs from floor((N-1)/div). For a large divisor this shows within one tick period. A stale or overwritten staging byte shows up on the next high-byte read or low-byte write, as a value whose halves do not belong together. A flag that misses its match tick stays low when it is read right after the run stops, and the interrupt request for that flag stays low with it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [2:0] {
        ADDR_CNT_L  = 3'd0,
        ADDR_CNT_H  = 3'd1,
        ADDR_CMPA_L = 3'd2,
        ADDR_CMPA_H = 3'd3,
        ADDR_CMPB_L = 3'd4,
        ADDR_CMPB_H = 3'd5,
        ADDR_FLAGS  = 3'd6,
        ADDR_RSVD   = 3'd7
    } reg_addr_e;

    typedef enum logic {
        RUN_STOPPED = 1'b0,
        RUN_ACTIVE  = 1'b1
    } run_state_e;

    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_CTC    = 1'b1
    } wave_mode_e;

    localparam int NUM_FLAGS = 3;
    localparam int FLAG_A    = 0;
    localparam int FLAG_B    = 1;
    localparam int FLAG_OVF  = 2;

    // divisor for a select code; 0 means stopped
    function automatic int sel_divisor(input logic [2:0] sel);
        int d;
        unique case (sel)
            3'd1:    d = 1;
            3'd2:    d = 8;
            3'd3:    d = 64;
            3'd4:    d = 256;
            3'd5:    d = 1024;
            default: d = 0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter int PRE_W = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] clk_sel,
    output logic       tick
);

    run_state_e       state_q, state_d;
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] lim;
    logic             sel_valid;
    int               div_i;

    always_comb begin
        div_i     = sel_divisor(clk_sel);
        sel_valid = (div_i > 0);
        lim       = sel_valid ? PRE_W'(div_i - 1) : '0;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RUN_STOPPED;
        else        state_q <= state_d;
    end

    // next state and tick output
    always_comb begin
        state_d = state_q;
        tick    = 1'b0;
        unique case (state_q)
            RUN_STOPPED: begin
                if (sel_valid) state_d = RUN_ACTIVE;
            end
            RUN_ACTIVE: begin
                tick = sel_valid && (pre_q >= lim);
                if (!sel_valid) state_d = RUN_STOPPED;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                                pre_q <= '0;
        else if (state_q == RUN_STOPPED || !sel_valid) pre_q <= '0;
        else if (tick)                             pre_q <= '0;
        else                                       pre_q <= pre_q + 1'b1;
    end

    // R2: back-to-back ticks only with divide by 1
    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && $past(tick)) |-> (clk_sel == 3'd1));

endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 ctc_mode,
    input  logic [CNT_W-1:0]     cmp_a,
    input  logic [CNT_W-1:0]     cmp_b,
    input  logic                 cnt_wr,
    input  logic [CNT_W-1:0]     cnt_wdata,
    input  logic [NUM_FLAGS-1:0] flag_clr,
    input  logic [NUM_FLAGS-1:0] flag_ack,
    output logic [CNT_W-1:0]     cnt_q,
    output logic [NUM_FLAGS-1:0] flags_q
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    wave_mode_e           mode;
    logic [CNT_W-1:0]     cnt_d;
    logic [NUM_FLAGS-1:0] set_vec;
    logic                 live_tick;

    assign mode      = ctc_mode ? MODE_CTC : MODE_NORMAL;
    assign live_tick = tick && !cnt_wr;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_wr) begin
            cnt_d = cnt_wdata;
        end else if (tick) begin
            unique case (mode)
                MODE_NORMAL: cnt_d = cnt_q + 1'b1;
                MODE_CTC:    cnt_d = (cnt_q == cmp_a) ? '0 : cnt_q + 1'b1;
            endcase
        end
    end

    always_comb begin
        set_vec           = '0;
        set_vec[FLAG_A]   = live_tick && (cnt_q == cmp_a);
        set_vec[FLAG_B]   = live_tick && (cnt_q == cmp_b);
        set_vec[FLAG_OVF] = live_tick && (cnt_q == CNT_MAX);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            flags_q <= '0;
        end else begin
            cnt_q   <= cnt_d;
            flags_q <= (flags_q & ~(flag_clr | flag_ack)) | set_vec;
        end
    end

    // R12: no tick and no write leaves the count alone
    a_r12_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_wr) |=> $stable(cnt_q));

    // R4: clear-on-match returns to zero
    a_r4_ctc_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (live_tick && ctc_mode && cnt_q == cmp_a) |=> (cnt_q == '0));

    // R5: match B raises its flag
    a_r5_match_b_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (live_tick && cnt_q == cmp_b) |=> flags_q[FLAG_B]);

    // R6: tick at all ones raises overflow
    a_r6_ovf_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (live_tick && cnt_q == CNT_MAX) |=> flags_q[FLAG_OVF]);

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2:0]             bus_addr,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    input  logic [DATA_W-1:0]      bus_wdata,
    output logic [DATA_W-1:0]      bus_rdata,
    input  logic [2*DATA_W-1:0]    cnt_q,
    input  logic [NUM_FLAGS-1:0]   flags_q,
    output logic                   cnt_wr,
    output logic [2*DATA_W-1:0]    cnt_wdata,
    output logic [2*DATA_W-1:0]    cmp_a,
    output logic [2*DATA_W-1:0]    cmp_b,
    output logic [NUM_FLAGS-1:0]   flag_clr
);

    reg_addr_e         addr;
    logic [DATA_W-1:0] temp_q, temp_d;
    logic              cmpa_wr, cmpb_wr;

    assign addr      = reg_addr_e'(bus_addr);
    assign cnt_wdata = {temp_q, bus_wdata};

    always_comb begin
        temp_d    = temp_q;
        cnt_wr    = 1'b0;
        cmpa_wr   = 1'b0;
        cmpb_wr   = 1'b0;
        flag_clr  = '0;
        bus_rdata = '0;
        unique case (addr)
            ADDR_CNT_L: begin
                bus_rdata = cnt_q[DATA_W-1:0];
                cnt_wr    = bus_wr;
                if (bus_rd) temp_d = cnt_q[2*DATA_W-1:DATA_W];
            end
            ADDR_CMPA_L: begin
                bus_rdata = cmp_a[DATA_W-1:0];
                cmpa_wr   = bus_wr;
                if (bus_rd) temp_d = cmp_a[2*DATA_W-1:DATA_W];
            end
            ADDR_CMPB_L: begin
                bus_rdata = cmp_b[DATA_W-1:0];
                cmpb_wr   = bus_wr;
                if (bus_rd) temp_d = cmp_b[2*DATA_W-1:DATA_W];
            end
            ADDR_CNT_H, ADDR_CMPA_H, ADDR_CMPB_H: begin
                bus_rdata = temp_q;
                if (bus_wr) temp_d = bus_wdata;
            end
            ADDR_FLAGS: begin
                bus_rdata = {{(DATA_W-NUM_FLAGS){1'b0}}, flags_q};
                if (bus_wr) flag_clr = bus_wdata[NUM_FLAGS-1:0];
            end
            ADDR_RSVD: begin
                bus_rdata = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            temp_q <= '0;
            cmp_a  <= '0;
            cmp_b  <= '0;
        end else begin
            temp_q <= temp_d;
            if (cmpa_wr) cmp_a <= {temp_q, bus_wdata};
            if (cmpb_wr) cmp_b <= {temp_q, bus_wdata};
        end
    end

    // R10: a high-byte write does not reach compare A
    a_r10_high_write_staged: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && addr == ADDR_CMPA_H) |=> $stable(cmp_a));

    // R11: a high-byte read leaves the staging byte alone
    a_r11_high_read_keeps_temp: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && addr == ADDR_CNT_H) |=> $stable(temp_q));

endmodule

// File: rtl/prescaled_timer16.sv
module prescaled_timer16
    import tmr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PRE_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        clk_sel,
    input  logic              ctc_mode,
    input  logic [2:0]        irq_en,
    input  logic [2:0]        irq_ack,
    input  logic [2:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              flag_cmp_a,
    output logic              flag_cmp_b,
    output logic              flag_ovf,
    output logic              irq_cmp_a,
    output logic              irq_cmp_b,
    output logic              irq_ovf
);

    localparam int CNT_W = 2 * DATA_W;

    logic                 tick;
    logic [CNT_W-1:0]     cnt_q, cnt_wdata, cmp_a, cmp_b;
    logic                 cnt_wr;
    logic [NUM_FLAGS-1:0] flags_q, flag_clr, irq_vec;

    tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clk_sel (clk_sel),
        .tick    (tick)
    );

    tmr_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cnt_q     (cnt_q),
        .flags_q   (flags_q),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (cnt_wdata),
        .cmp_a     (cmp_a),
        .cmp_b     (cmp_b),
        .flag_clr  (flag_clr)
    );

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .ctc_mode  (ctc_mode),
        .cmp_a     (cmp_a),
        .cmp_b     (cmp_b),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (cnt_wdata),
        .flag_clr  (flag_clr),
        .flag_ack  (irq_ack),
        .cnt_q     (cnt_q),
        .flags_q   (flags_q)
    );

    assign irq_vec    = flags_q & irq_en;
    assign flag_cmp_a = flags_q[FLAG_A];
    assign flag_cmp_b = flags_q[FLAG_B];
    assign flag_ovf   = flags_q[FLAG_OVF];
    assign irq_cmp_a  = irq_vec[FLAG_A];
    assign irq_cmp_b  = irq_vec[FLAG_B];
    assign irq_ovf    = irq_vec[FLAG_OVF];

endmodule

// File: tb/tb_prescaled_timer16.sv
module tb_prescaled_timer16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] clk_sel = '0;
    logic       ctc_mode = 1'b0;
    logic [2:0] irq_en = '0;
    logic [2:0] irq_ack = '0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       flag_cmp_a, flag_cmp_b, flag_ovf;
    logic       irq_cmp_a, irq_cmp_b, irq_ovf;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    prescaled_timer16 dut (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .ctc_mode(ctc_mode),
        .irq_en(irq_en), .irq_ack(irq_ack), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .flag_cmp_a(flag_cmp_a), .flag_cmp_b(flag_cmp_b),
        .flag_ovf(flag_ovf), .irq_cmp_a(irq_cmp_a), .irq_cmp_b(irq_cmp_b),
        .irq_ovf(irq_ovf)
    );

    typedef struct packed {
        logic [2:0]  sel;
        logic        ctc;
        logic [15:0] cmpa;
        logic [31:0] edges;
        logic [15:0] exp_cnt;
        logic        exp_a;
    } vec_t;

    // expected count = floor((edges-1)/div), reduced mod (cmpa+1) in clear-on-match
    localparam vec_t VECS [7] = '{
        '{3'd1, 1'b0, 16'd100, 32'd51,    16'd50, 1'b0},
        '{3'd2, 1'b0, 16'd3,   32'd41,    16'd5,  1'b1},
        '{3'd1, 1'b1, 16'd9,   32'd26,    16'd5,  1'b1},
        '{3'd3, 1'b1, 16'd2,   32'd641,   16'd1,  1'b1},
        '{3'd4, 1'b0, 16'd500, 32'd2561,  16'd10, 1'b0},
        '{3'd5, 1'b1, 16'd4,   32'd10241, 16'd0,  1'b1},
        '{3'd1, 1'b1, 16'd255, 32'd300,   16'd43, 1'b1}
    };

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bwr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic brd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr16(input logic [2:0] lo, input logic [15:0] v);
        bwr(lo + 3'd1, v[15:8]);
        bwr(lo, v[7:0]);
    endtask

    task automatic rd16(input logic [2:0] lo, output logic [15:0] v);
        logic [7:0] l, h;
        brd(lo, l);
        brd(lo + 3'd1, h);
        v = {h, l};
    endtask

    task automatic run_for(input logic [2:0] s, input logic m, input int n);
        @(negedge clk);
        ctc_mode = m; clk_sel = s;
        repeat (n) @(posedge clk);
        @(negedge clk);
        clk_sel = 3'd0;
        #1;
    endtask

    task automatic summary;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [15:0] v;
        logic [7:0]  b;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        #1;
        chk("R1 flags", {flag_ovf, flag_cmp_b, flag_cmp_a}, 0);
        chk("R1 irq", {irq_ovf, irq_cmp_b, irq_cmp_a}, 0);
        rd16(3'd0, v);  chk("R1 counter", v, 0);
        rd16(3'd2, v);  chk("R1 compare A", v, 0);

        // stimulus table: R2 divisors, R3 free-running, R4 clear-on-match, R5 match A
        foreach (VECS[i]) begin
            bwr(3'd6, 8'h07);
            wr16(3'd0, 16'd0);
            wr16(3'd2, VECS[i].cmpa);
            wr16(3'd4, 16'hFFF0);
            run_for(VECS[i].sel, VECS[i].ctc, int'(VECS[i].edges));
            chk("R5 match A flag", flag_cmp_a, VECS[i].exp_a);
            rd16(3'd0, v);
            chk(VECS[i].ctc ? "R4 count" : "R2 R3 count", v, VECS[i].exp_cnt);
        end

        // R10 high write alone is only staged
        wr16(3'd0, 16'h1234);
        rd16(3'd0, v); chk("R10 atomic write", v, 16'h1234);
        bwr(3'd1, 8'hAB);
        rd16(3'd0, v); chk("R10 high byte staged only", v, 16'h1234);

        // R11 low read latches high byte
        wr16(3'd0, 16'h00FF);
        brd(3'd0, b); chk("R11 low byte", b, 8'hFF);
        run_for(3'd1, 1'b0, 3);
        brd(3'd1, b); chk("R11 latched high byte", b, 8'h00);
        rd16(3'd0, v); chk("R11 fresh read", v, 16'h0101);

        // R6 overflow and R7 gating, R9 acknowledge
        bwr(3'd6, 8'h07);
        wr16(3'd2, 16'h0010);
        wr16(3'd0, 16'hFFFE);
        irq_en = 3'b100;
        run_for(3'd1, 1'b0, 4);
        chk("R6 overflow flag", flag_ovf, 1);
        chk("R7 irq enabled", irq_ovf, 1);
        rd16(3'd0, v); chk("R3 wrap count", v, 16'h0001);
        @(negedge clk) irq_en = 3'b000;
        #1 chk("R7 irq masked", irq_ovf, 0);
        chk("R7 flag kept when masked", flag_ovf, 1);
        @(negedge clk) irq_ack = 3'b100;
        @(negedge clk) irq_ack = 3'b000;
        #1 chk("R9 ack clears", flag_ovf, 0);

        // R5 match B, R8 write-one-to-clear
        wr16(3'd2, 16'd5);
        wr16(3'd4, 16'd5);
        wr16(3'd0, 16'd0);
        bwr(3'd6, 8'h07);
        run_for(3'd1, 1'b0, 7);
        chk("R5 match B flag", flag_cmp_b, 1);
        bwr(3'd6, 8'h02);
        brd(3'd6, b); chk("R8 clear only B", b, 8'h01);
        bwr(3'd6, 8'h00);
        brd(3'd6, b); chk("R8 zero write no effect", b, 8'h01);

        // R12 stopped and R2 reserved codes hold the count
        wr16(3'd0, 16'h0042);
        repeat (50) @(posedge clk);
        rd16(3'd0, v); chk("R12 stopped hold", v, 16'h0042);
        run_for(3'd6, 1'b0, 50);
        rd16(3'd0, v); chk("R2 code 6 stops", v, 16'h0042);

        summary();
    end

endmodule